// File: doc/BRIEF.md
# Miss Tracker with Speculative-Load Merging

This block keeps the record of line-granular requests that a core has sent toward the memory system and that are still waiting for a fill. Reads and writes each have their own small table, keyed by line address. For every request the block decides, in the cycle it is accepted, whether the request issues toward memory, merges with an outstanding request, or is reported as aliased so that the core retries it later.

Only one combination merges: a speculative load to a line whose outstanding read is also a speculative load. The new load is attached to that entry as a dependent and nothing is sent to memory. When the fill for the line returns, the block plays out one completion per cycle. The dependents come first, in the order they merged, and the primary request comes last. Each completion carries its own bytes cut from the returned line, and each carries a level-one-hit flag taken from the fill. The table entry is released on the same clock edge that ends the primary completion.

Exposure and validation requests both travel as the expose kind. They take a read-table entry and carry no write-data payload.

Top module: `miss_tracker`

## Requirements
- R1: After reset, no entry is outstanding. `out_count` and `ld_on_ld` are 0, `cpl_valid` and `iss_valid` are 0, and `req_ready` and `fill_ready` are 1.
- R2: Kind encoding is 0 load, 1 speculative load, 2 expose, 3 store. Status encoding is 0 issued, 1 merged, 2 aliased. An accepted request whose line is in neither table reports issued. In that same cycle `iss_valid` is 1 and `iss_line`, `iss_kind` and `iss_tag` equal the request's fields. `iss_payload` is 1 for a store only, so it is 0 for an expose. In any other cycle `iss_valid` is 0.
- R3: A speculative load to a line whose read entry is a speculative load with fewer than DEPS dependents reports merged. It does not issue and is completed with that entry's fill.
- R4: A speculative load that finds a read entry that is not speculative, or whose dependent list is already full, reports aliased. `ld_on_ld` increments by one in that case.
- R5: A load or expose that finds a read entry for its line reports aliased and increments `ld_on_ld`.
- R6: Any request whose line has a write entry, and a store whose line has a read entry, reports aliased. `ld_on_ld` is left unchanged in these cases.
- R7: A fill is accepted when `fill_valid` and `fill_ready` are both high. From the next cycle on, one completion appears per cycle: the dependents in merge order, then the primary. For a load or speculative load, `cpl_data` holds the fill bytes starting at the request's byte offset, for its size, placed from byte 0 upward with the rest zero. A store or expose completes with zero data. `cpl_kind` and `cpl_tag` identify the request.
- R8: `cpl_l1hit` is the inverse of the fill's `fill_external`, for every completion that fill produces.
- R9: `out_count` rises on the edge after an issue. It falls on the edge that ends a primary completion, and the entry is free from that edge on.
- R10: `req_ready` is 0 while a completion sequence is running, while `fill_valid` is high, or while the table the request targets (the read table for kinds 0 to 2, the write table for kind 3) is full. `fill_ready` is 0 while a completion sequence runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted this cycle |
| req_kind | input | 2 | Request kind |
| req_line | input | LINE_W | Line address |
| req_tag | input | TAG_W | Core-side request identifier |
| req_off | input | OFF_W | Byte offset within the line |
| req_size | input | SIZE_W | Byte count |
| req_status | output | 2 | Decision for the current request |
| iss_valid | output | 1 | Request sent toward memory |
| iss_kind | output | 2 | Kind of the issued request |
| iss_line | output | LINE_W | Line of the issued request |
| iss_tag | output | TAG_W | Tag of the issued request |
| iss_payload | output | 1 | Issued request carries write data |
| fill_valid | input | 1 | Fill response present |
| fill_ready | output | 1 | Fill can be accepted |
| fill_write | input | 1 | Fill belongs to the write table |
| fill_line | input | LINE_W | Line of the fill |
| fill_external | input | 1 | Fill was served from outside the level-one cache |
| fill_data | input | DATA_W | Returned line |
| cpl_valid | output | 1 | Completion present |
| cpl_kind | output | 2 | Kind of the completed request |
| cpl_tag | output | TAG_W | Tag of the completed request |
| cpl_data | output | DATA_W | Bytes for the completed request |
| cpl_l1hit | output | 1 | Completion counts as a level-one hit |
| out_count | output | OCNT_W | Entries outstanding in both tables |
| ld_on_ld | output | CNT_W | Read-on-read alias count (wraps) |

## Verification
The assertions assume three things about the inputs. Every accepted fill names a line that has an entry in the table selected by `fill_write`. The byte offset plus size of a request never runs past the end of the line. No second fill arrives for a line until its first one has been played out. The stimulus keeps to all three: fills are raised only for lines that the bench model holds, and only while no completion sequence is running; offsets and sizes are drawn so that they fit the line; and each fill retires its entry. Merges, dependent-list overflow, the alias combinations and full-table back-pressure are first reached in a directed pass. A random pass over four lines then mixes them.

// File: rtl/orq_pkg.sv
// Shared kinds and decisions for the miss tracker.
// Assumes: encodings are fixed, because the core and the memory side decode them.
package orq_pkg;
    typedef enum logic [1:0] {
        K_LOAD   = 2'd0,
        K_SPEC   = 2'd1,
        K_EXPOSE = 2'd2,
        K_STORE  = 2'd3
    } kind_t;

    typedef enum logic [1:0] {
        ST_ISSUED  = 2'd0,
        ST_MERGED  = 2'd1,
        ST_ALIASED = 2'd2
    } status_t;
endpackage

// File: rtl/orq_match.sv
// Fully associative line lookup over one table.
// Assumes: at most one valid entry holds a given line.
module orq_match #(
    parameter int N      = 4,
    parameter int LINE_W = 16,
    localparam int IW    = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]             valid,
    input  logic [N-1:0][LINE_W-1:0] lines,
    input  logic [LINE_W-1:0]        key,
    output logic                     hit,
    output logic [IW-1:0]            idx
);
    logic [N-1:0] eq;

    // per-entry compare
    for (genvar g = 0; g < N; g++) begin : g_cmp
        assign eq[g] = valid[g] && (lines[g] == key);
    end

    // encode the matching position
    always_comb begin
        hit = |eq;
        idx = '0;
        for (int i = 0; i < N; i++) begin
            if (eq[i]) idx = IW'(i);
        end
    end
endmodule

// File: rtl/orq_first_free.sv
// Picks the lowest-numbered free entry of a table.
// Assumes: nothing beyond a valid vector.
module orq_first_free #(
    parameter int N   = 4,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  valid,
    output logic          any_free,
    output logic [IW-1:0] idx
);
    // scan from the top so that the lowest free slot wins
    always_comb begin
        any_free = ~&valid;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (!valid[i]) idx = IW'(i);
        end
    end
endmodule

// File: rtl/miss_tracker.sv
// Outstanding request tracker with separate read and write tables.
// It decides issue / merge / alias for each request, and it plays out
// completions (dependents first, primary last) after each fill.
// Assumes: each accepted fill names an outstanding line in the table chosen
// by fill_write, and req_off + req_size never exceeds LINE_BYTES.
module miss_tracker #(
    parameter int LINE_W     = 16,
    parameter int TAG_W      = 4,
    parameter int LINE_BYTES = 8,
    parameter int RD_ENTRIES = 4,
    parameter int WR_ENTRIES = 4,
    parameter int DEPS       = 2,
    parameter int CNT_W      = 8,
    localparam int DATA_W    = LINE_BYTES * 8,
    localparam int OFF_W     = $clog2(LINE_BYTES),
    localparam int SIZE_W    = $clog2(LINE_BYTES) + 1,
    localparam int OCNT_W    = $clog2(RD_ENTRIES + WR_ENTRIES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [1:0]        req_kind,
    input  logic [LINE_W-1:0] req_line,
    input  logic [TAG_W-1:0]  req_tag,
    input  logic [OFF_W-1:0]  req_off,
    input  logic [SIZE_W-1:0] req_size,
    output logic [1:0]        req_status,
    output logic              iss_valid,
    output logic [1:0]        iss_kind,
    output logic [LINE_W-1:0] iss_line,
    output logic [TAG_W-1:0]  iss_tag,
    output logic              iss_payload,
    input  logic              fill_valid,
    output logic              fill_ready,
    input  logic              fill_write,
    input  logic [LINE_W-1:0] fill_line,
    input  logic              fill_external,
    input  logic [DATA_W-1:0] fill_data,
    output logic              cpl_valid,
    output logic [1:0]        cpl_kind,
    output logic [TAG_W-1:0]  cpl_tag,
    output logic [DATA_W-1:0] cpl_data,
    output logic              cpl_l1hit,
    output logic [OCNT_W-1:0] out_count,
    output logic [CNT_W-1:0]  ld_on_ld
);
    import orq_pkg::*;

    localparam int RIW    = (RD_ENTRIES > 1) ? $clog2(RD_ENTRIES) : 1;
    localparam int WIW    = (WR_ENTRIES > 1) ? $clog2(WR_ENTRIES) : 1;
    localparam int DCNT_W = $clog2(DEPS + 1);
    localparam int DSEL_W = (DEPS > 1) ? $clog2(DEPS) : 1;

    // read table
    logic [RD_ENTRIES-1:0]             rd_valid;
    logic [RD_ENTRIES-1:0][LINE_W-1:0] rd_line;
    kind_t                             rd_kind [RD_ENTRIES];
    logic [TAG_W-1:0]                  rd_tag  [RD_ENTRIES];
    logic [OFF_W-1:0]                  rd_off  [RD_ENTRIES];
    logic [SIZE_W-1:0]                 rd_size [RD_ENTRIES];
    logic [DCNT_W-1:0]                 rd_ndep [RD_ENTRIES];
    logic [TAG_W-1:0]                  dep_tag  [RD_ENTRIES][DEPS];
    logic [OFF_W-1:0]                  dep_off  [RD_ENTRIES][DEPS];
    logic [SIZE_W-1:0]                 dep_size [RD_ENTRIES][DEPS];
    // write table
    logic [WR_ENTRIES-1:0]             wr_valid;
    logic [WR_ENTRIES-1:0][LINE_W-1:0] wr_line;
    logic [TAG_W-1:0]                  wr_tag [WR_ENTRIES];
    // completion sequencer
    logic              busy, d_write, d_l1hit;
    logic [RIW-1:0]    d_ridx;
    logic [WIW-1:0]    d_widx;
    logic [DCNT_W-1:0] d_pos, d_ndep;
    logic [DATA_W-1:0] d_data;
    logic              at_primary, retire;

    kind_t             rk;
    status_t           st;
    logic [LINE_W-1:0] key;
    logic              rd_hit, wr_hit, rd_free, wr_free, is_rd, can_merge;
    logic              accept, issued, merged, ldld_inc, fill_go;
    logic [RIW-1:0]    rd_hidx, rd_fidx;
    logic [WIW-1:0]    wr_hidx, wr_fidx;
    logic [DSEL_W-1:0] m_slot, d_sel;

    // the fill owns the lookup whenever it is present; requests are held off then
    assign key = fill_valid ? fill_line : req_line;

    orq_match #(.N(RD_ENTRIES), .LINE_W(LINE_W)) i_rd_match (
        .valid(rd_valid), .lines(rd_line), .key(key), .hit(rd_hit), .idx(rd_hidx));
    orq_match #(.N(WR_ENTRIES), .LINE_W(LINE_W)) i_wr_match (
        .valid(wr_valid), .lines(wr_line), .key(key), .hit(wr_hit), .idx(wr_hidx));
    orq_first_free #(.N(RD_ENTRIES)) i_rd_free (
        .valid(rd_valid), .any_free(rd_free), .idx(rd_fidx));
    orq_first_free #(.N(WR_ENTRIES)) i_wr_free (
        .valid(wr_valid), .any_free(wr_free), .idx(wr_fidx));

    // cut size bytes at byte offset off out of a returned line
    function automatic logic [DATA_W-1:0] pick_bytes(input logic [DATA_W-1:0] ln,
                                                     input logic [OFF_W-1:0] off,
                                                     input logic [SIZE_W-1:0] sz);
        logic [DATA_W-1:0] r;
        r = '0;
        for (int b = 0; b < LINE_BYTES; b++) begin
            if (b < int'(sz) && int'(off) + b < LINE_BYTES)
                r[b*8 +: 8] = ln[(int'(off) + b)*8 +: 8];
        end
        return r;
    endfunction

    // request decision: issue, merge or alias
    always_comb begin
        rk        = kind_t'(req_kind);
        is_rd     = (rk != K_STORE);
        can_merge = is_rd && rk == K_SPEC && rd_hit && rd_kind[rd_hidx] == K_SPEC
                    && rd_ndep[rd_hidx] < DCNT_W'(DEPS);
        if (rd_hit || wr_hit) st = can_merge ? ST_MERGED : ST_ALIASED;
        else                  st = ST_ISSUED;
        req_ready = !busy && !fill_valid && (is_rd ? rd_free : wr_free);
        accept    = req_valid && req_ready;
        issued    = accept && st == ST_ISSUED;
        merged    = accept && st == ST_MERGED;
        ldld_inc  = accept && is_rd && rd_hit && !can_merge;
        m_slot    = rd_ndep[rd_hidx][DSEL_W-1:0];
    end

    assign req_status  = st;
    assign iss_valid   = issued;
    assign iss_kind    = req_kind;
    assign iss_line    = req_line;
    assign iss_tag     = req_tag;
    assign iss_payload = (rk == K_STORE);

    assign fill_ready = !busy;
    assign fill_go    = fill_valid && !busy;

    // completion view of the entry being drained
    always_comb begin
        d_ndep     = d_write ? '0 : rd_ndep[d_ridx];
        at_primary = (d_pos == d_ndep);
        retire     = busy && at_primary;
        d_sel      = d_pos[DSEL_W-1:0];
        cpl_valid  = busy;
        cpl_l1hit  = d_l1hit;
        if (d_write) begin
            cpl_kind = K_STORE;
            cpl_tag  = wr_tag[d_widx];
            cpl_data = '0;
        end else if (at_primary) begin
            cpl_kind = rd_kind[d_ridx];
            cpl_tag  = rd_tag[d_ridx];
            cpl_data = (rd_kind[d_ridx] == K_LOAD || rd_kind[d_ridx] == K_SPEC)
                       ? pick_bytes(d_data, rd_off[d_ridx], rd_size[d_ridx]) : '0;
        end else begin
            cpl_kind = K_SPEC;
            cpl_tag  = dep_tag[d_ridx][d_sel];
            cpl_data = pick_bytes(d_data, dep_off[d_ridx][d_sel], dep_size[d_ridx][d_sel]);
        end
    end

    // control state: valid bits, dependent counts, sequencer, counters
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid  <= '0;
            wr_valid  <= '0;
            busy      <= 1'b0;
            d_pos     <= '0;
            d_write   <= 1'b0;
            d_ridx    <= '0;
            d_widx    <= '0;
            out_count <= '0;
            ld_on_ld  <= '0;
            for (int i = 0; i < RD_ENTRIES; i++) rd_ndep[i] <= '0;
        end else begin
            if (issued && is_rd) begin
                rd_valid[rd_fidx] <= 1'b1;
                rd_ndep[rd_fidx]  <= '0;
            end
            if (issued && !is_rd) wr_valid[wr_fidx] <= 1'b1;
            if (merged) rd_ndep[rd_hidx] <= rd_ndep[rd_hidx] + DCNT_W'(1);
            if (ldld_inc) ld_on_ld <= ld_on_ld + CNT_W'(1);
            if (fill_go) begin
                busy    <= 1'b1;
                d_pos   <= '0;
                d_write <= fill_write;
                d_ridx  <= rd_hidx;
                d_widx  <= wr_hidx;
            end else if (busy) begin
                if (at_primary) begin
                    busy <= 1'b0;
                    if (d_write) wr_valid[d_widx] <= 1'b0;
                    else         rd_valid[d_ridx] <= 1'b0;
                end else begin
                    d_pos <= d_pos + DCNT_W'(1);
                end
            end
            out_count <= out_count + OCNT_W'(issued) - OCNT_W'(retire);
        end
    end

    // payload state: line, tag, bytes and fill data (no reset needed)
    always_ff @(posedge clk) begin
        if (issued && is_rd) begin
            rd_line[rd_fidx] <= req_line;
            rd_kind[rd_fidx] <= rk;
            rd_tag[rd_fidx]  <= req_tag;
            rd_off[rd_fidx]  <= req_off;
            rd_size[rd_fidx] <= req_size;
        end
        if (issued && !is_rd) begin
            wr_line[wr_fidx] <= req_line;
            wr_tag[wr_fidx]  <= req_tag;
        end
        if (merged) begin
            dep_tag[rd_hidx][m_slot]  <= req_tag;
            dep_off[rd_hidx][m_slot]  <= req_off;
            dep_size[rd_hidx][m_slot] <= req_size;
        end
        if (fill_go) begin
            d_data  <= fill_data;
            d_l1hit <= !fill_external;
        end
    end

    // ---- assertions ----
    // R10: a full read table refuses read-class requests
    a_r10_rd_full_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_kind != 2'd3 && &rd_valid) |-> !req_ready);
    // R7 / R10: both input ports are held off while completions play out
    a_r7_drain_blocks_ports: assert property (@(posedge clk) disable iff (!rst_n)
        cpl_valid |-> (!req_ready && !fill_ready));
    // R9: the running count agrees with the occupied entries
    a_r9_count_tracks: assert property (@(posedge clk) disable iff (!rst_n)
        int'(out_count) == $countones(rd_valid) + $countones(wr_valid));
    // R9: a primary read completion leaves its entry free on the next cycle
    a_r9_primary_frees: assert property (@(posedge clk) disable iff (!rst_n)
        (retire && !d_write) |=> !rd_valid[$past(d_ridx)]);
    // R4: the alias counter steps by at most one
    a_r4_ldld_step: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (ld_on_ld == $past(ld_on_ld) || ld_on_ld == $past(ld_on_ld) + CNT_W'(1)));
    // R7: an accepted fill names an outstanding line
    a_r7_fill_known: assert property (@(posedge clk) disable iff (!rst_n)
        fill_go |-> (fill_write ? wr_hit : rd_hit));
    // R3: dependent lists never exceed their depth
    for (genvar g = 0; g < RD_ENTRIES; g++) begin : g_dep_chk
        a_r3_dep_bound: assert property (@(posedge clk) disable iff (!rst_n)
            rd_ndep[g] <= DCNT_W'(DEPS));
    end
endmodule

// File: tb/test_miss_tracker.sv
`timescale 1ns/1ps
module test_miss_tracker;
    localparam int RD = 4, WR = 4, DEPS = 2;

    logic        clk = 1'b0, rst_n = 1'b0;
    logic        req_valid = 0, fill_valid = 0, fill_write = 0, fill_external = 0;
    logic [1:0]  req_kind = 0;
    logic [15:0] req_line = 0, fill_line = 0;
    logic [3:0]  req_tag = 0;
    logic [2:0]  req_off = 0;
    logic [3:0]  req_size = 0;
    logic [63:0] fill_data = 0;
    logic        req_ready, iss_valid, iss_payload, fill_ready, cpl_valid, cpl_l1hit;
    logic [1:0]  req_status, iss_kind, cpl_kind;
    logic [15:0] iss_line;
    logic [3:0]  iss_tag, cpl_tag, out_count;
    logic [63:0] cpl_data;
    logic [7:0]  ld_on_ld;

    miss_tracker i_miss_tracker (.*);

    always #2.5 clk = ~clk;

    typedef struct { int line; int kind; int tag; int off; int sz; } rec_t;
    typedef struct { int tag; int kind; logic [63:0] data; bit l1; bit prim; bit wr; int line; } cpl_t;
    rec_t rdq[$], wrq[$], depq[$];
    cpl_t cq[$];
    int   ldld = 0, compared = 0, mismatched = 0;
    bit   done = 0;

    task automatic chk(bit ok, string rq, string what, longint act, longint exp);
        compared++;
        if (!ok) begin
            mismatched++;
            $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
        end
    endtask

    function automatic int find_q(ref rec_t q[$], input int line);
        for (int i = 0; i < q.size(); i++) if (q[i].line == line) return i;
        return -1;
    endfunction

    function automatic int ndeps(int line);
        int n = 0;
        for (int i = 0; i < depq.size(); i++) if (depq[i].line == line) n++;
        return n;
    endfunction

    function automatic logic [63:0] cut(logic [63:0] d, int off, int sz);
        logic [63:0] r = '0;
        for (int b = 0; b < 8; b++)
            if (b < sz && off + b < 8) r[b*8 +: 8] = d[(off + b)*8 +: 8];
        return r;
    endfunction

    // one cycle: compare every output against the model, then advance the model
    task automatic tick();
        bit busy, is_rd, full, rdy, acc;
        int ri, wi, st;
        string tagname;
        #1;
        busy  = cq.size() > 0;
        is_rd = (req_kind != 2'd3);
        full  = is_rd ? rdq.size() >= RD : wrq.size() >= WR;
        rdy   = !busy && !fill_valid && !full;
        chk(req_ready == rdy, "R10", "req_ready", req_ready, rdy);
        chk(fill_ready == !busy, "R10", "fill_ready", fill_ready, !busy);
        acc = req_valid && rdy;
        ri  = find_q(rdq, req_line);
        wi  = find_q(wrq, req_line);
        st  = 0; tagname = "R2";
        if (acc) begin
            if (is_rd && req_kind == 2'd1 && ri >= 0 && rdq[ri].kind == 1 && ndeps(req_line) < DEPS) begin
                st = 1; tagname = "R3";
            end else if (wi >= 0 || (!is_rd && ri >= 0)) begin
                st = 2; tagname = "R6";
            end else if (ri >= 0) begin
                st = 2; tagname = (req_kind == 2'd1) ? "R4" : "R5";
            end
            chk(req_status == st[1:0], tagname, "req_status", req_status, st);
            chk(iss_valid == (st == 0), tagname, "iss_valid", iss_valid, st == 0);
            if (st == 0) begin
                chk(iss_line == req_line && iss_tag == req_tag && iss_kind == req_kind,
                    "R2", "iss fields", {iss_line, iss_tag, iss_kind}, {req_line, req_tag, req_kind});
                chk(iss_payload == (req_kind == 2'd3), "R2", "iss_payload", iss_payload, req_kind == 2'd3);
            end
        end else begin
            chk(iss_valid == 1'b0, "R2", "iss_valid idle", iss_valid, 0);
        end
        chk(cpl_valid == busy, "R7", "cpl_valid", cpl_valid, busy);
        if (busy) begin
            chk(cpl_tag == cq[0].tag[3:0] && cpl_kind == cq[0].kind[1:0], "R7", "cpl tag/kind",
                {cpl_tag, cpl_kind}, {cq[0].tag[3:0], cq[0].kind[1:0]});
            chk(cpl_data == cq[0].data, "R7", "cpl_data", cpl_data, cq[0].data);
            chk(cpl_l1hit == cq[0].l1, "R8", "cpl_l1hit", cpl_l1hit, cq[0].l1);
        end
        chk(out_count == 4'(rdq.size() + wrq.size()), "R9", "out_count", out_count, rdq.size() + wrq.size());
        chk(ld_on_ld == 8'(ldld), "R4", "ld_on_ld", ld_on_ld, ldld & 255);
        // advance the model to the state after the coming edge
        if (busy) begin
            cpl_t c = cq.pop_front();
            if (c.prim) begin
                if (c.wr) wrq.delete(find_q(wrq, c.line));
                else      rdq.delete(find_q(rdq, c.line));
            end
        end
        if (acc) begin
            rec_t r;
            r.line = req_line; r.kind = req_kind; r.tag = req_tag; r.off = req_off; r.sz = req_size;
            if (st == 0 && is_rd) rdq.push_back(r);
            else if (st == 0) wrq.push_back(r);
            else if (st == 1) depq.push_back(r);
            else if (is_rd && ri >= 0) ldld++;
        end
        if (fill_valid && !busy) begin
            cpl_t c;
            c.l1 = !fill_external; c.wr = fill_write; c.line = fill_line;
            if (fill_write) begin
                wi = find_q(wrq, fill_line);
                c.tag = wrq[wi].tag; c.kind = 3; c.data = '0; c.prim = 1;
                cq.push_back(c);
            end else begin
                for (int i = 0; i < depq.size(); i++) begin
                    if (depq[i].line == fill_line) begin
                        c.tag = depq[i].tag; c.kind = 1; c.prim = 0;
                        c.data = cut(fill_data, depq[i].off, depq[i].sz);
                        cq.push_back(c);
                    end
                end
                for (int i = depq.size() - 1; i >= 0; i--)
                    if (depq[i].line == fill_line) depq.delete(i);
                ri = find_q(rdq, fill_line);
                c.tag = rdq[ri].tag; c.kind = rdq[ri].kind; c.prim = 1;
                c.data = (rdq[ri].kind <= 1) ? cut(fill_data, rdq[ri].off, rdq[ri].sz) : '0;
                cq.push_back(c);
            end
        end
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic rq(int kind, int line, int tag, int off, int sz);
        req_valid = 1; req_kind = 2'(kind); req_line = 16'(line);
        req_tag = 4'(tag); req_off = 3'(off); req_size = 4'(sz);
        tick();
        req_valid = 0;
    endtask

    task automatic fl(bit wr, int line, bit ext, logic [63:0] d);
        fill_valid = 1; fill_write = wr; fill_line = 16'(line); fill_external = ext; fill_data = d;
        tick();
        fill_valid = 0;
        while (cq.size() > 0) tick();
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            mismatched++;
            compared++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        @(negedge clk);
        // R1: reset state
        chk(out_count == 0 && ld_on_ld == 0, "R1", "counters", {out_count, ld_on_ld}, 0);
        chk(!cpl_valid && !iss_valid && req_ready && fill_ready, "R1", "flags",
            {cpl_valid, iss_valid, req_ready, fill_ready}, 4'b0011);
        rst_n = 1;
        @(negedge clk);
        // directed: merging, overflow, alias kinds
        rq(1, 'h10, 1, 2, 2);   // R2 issue spec
        rq(1, 'h10, 2, 0, 4);   // R3 merge
        rq(1, 'h10, 3, 5, 3);   // R3 merge, list now full
        rq(1, 'h10, 4, 0, 1);   // R4 full list -> alias
        rq(0, 'h20, 5, 1, 4);   // R2 issue load
        rq(0, 'h20, 6, 0, 8);   // R5 alias
        rq(1, 'h20, 7, 0, 2);   // R4 spec on plain load
        rq(3, 'h20, 8, 0, 8);   // R6 store on read
        rq(3, 'h30, 9, 0, 8);   // R2 store payload
        rq(0, 'h30, 10, 0, 1);  // R6 load on write
        rq(2, 'h40, 11, 0, 8);  // R2 expose, no payload
        rq(2, 'h40, 12, 0, 8);  // R5 expose alias
        rq(0, 'h50, 13, 3, 5);  // fills read table
        rq(0, 'h60, 14, 0, 1);  // R10 refused: full
        req_valid = 1; req_kind = 0; req_line = 'h60;
        fill_valid = 1; fill_write = 0; fill_line = 'h10; fill_external = 0;
        fill_data = 64'h8877665544332211;
        tick();                 // R10: fill present blocks request
        fill_valid = 0;
        while (cq.size() > 0) tick();   // R7/R8 dependents then primary, R9 release
        req_valid = 0;
        fl(0, 'h20, 1, 64'hF0E0D0C0B0A09080);   // R8 external
        fl(1, 'h30, 0, 64'h1);
        fl(0, 'h40, 1, 64'h5555);
        fl(0, 'h50, 0, 64'h0102030405060708);
        // random mix over four lines
        for (int n = 0; n < 3000; n++) begin
            int r = $urandom % 4;
            int off = $urandom % 8;
            if (r == 0 && cq.size() == 0 && (rdq.size() + wrq.size()) > 0) begin
                bit usewr = (rdq.size() == 0) || (wrq.size() > 0 && ($urandom % 2 == 1));
                int ln = usewr ? wrq[$urandom % wrq.size()].line : rdq[$urandom % rdq.size()].line;
                fill_valid = 1; fill_write = usewr; fill_line = 16'(ln);
                fill_external = 1'($urandom % 2); fill_data = {$urandom, $urandom};
                req_valid = 1'($urandom % 2);
            end else begin
                fill_valid = 0;
                req_valid = (r != 3);
            end
            req_kind = 2'($urandom % 4); req_line = 16'('h100 + $urandom % 4);
            req_tag = 4'($urandom); req_off = 3'(off); req_size = 4'(1 + $urandom % (8 - off));
            tick();
            fill_valid = 0;
        end
        req_valid = 0;
        while (cq.size() > 0) tick();
        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule